// File: doc/BRIEF.md
# Variable Refresh Vertical Timing Generator

This block counts scanlines for one display pipe and lets each frame's vertical total stretch between a programmed minimum and maximum. A host programs line limits, a guardband, vsync offsets, a control word and a push register through a small word-wide register port. The timing side advances once per `line_tick`. It produces vblank and vsync levels, a one-cycle frame-start pulse, and a one-cycle latch strobe that marks when the double-buffered limits are taken over. It also reports whether variable timing is currently live.

While variable timing is live, a frame that reaches vblank waits there. When the host sets push-send, the vblank exit (the final guardband lines of the frame) starts on the following line. The exit can start no earlier than the flipline boundary (flipline total minus guardband). With no push, the frame runs to the vmax boundary (vmax total minus guardband). When variable timing is not live, every frame runs to vmax. Programming equal limits gives a constant frame length.

The frame sequencer has three states. ACTIVE covers active lines. VB_WAIT covers vblank lines before the exit has started. VB_EXIT counts down the guardband lines. The transitions are: ACTIVE to VB_WAIT on reaching the vblank start line, ACTIVE or VB_WAIT to VB_EXIT on a decision hit (the vmax boundary, or a pending push at or after the earliest boundary), VB_EXIT to VB_EXIT while guardband lines remain, and VB_EXIT to ACTIVE on wrap to line zero.

Top module: `vrr_vtiming`

Register map, with the word address on `reg_addr`:

| Address | Contents |
|---|---|
| 0 | minimum total, lines - 1 |
| 1 | maximum total, lines - 1 |
| 2 | flipline total, lines - 1 |
| 3 | control: bit 0 variable-timing enable, bit 1 flipline enable, bits 15:8 guardband |
| 4 | vsync: bits 11:0 start offset, bits 27:16 end offset |
| 5 | push: bit 0 push-enable, bit 1 push-send |
| 6 | read-only status: bit 0 live |

## Requirements
- R1: After a synchronous reset, all registers read 0 and `vblank`, `vsync`, `frame_start`, `reg_latch`, `vrr_live` and `line_num` are all 0.
- R2: The limit registers hold the line count minus one. When variable timing is not live, every frame lasts vmax+1 line ticks, whatever the push activity.
- R3: When variable timing is live and no push is pending, a frame lasts vmax+1 lines.
- R4: A push-send written during line y, where flip+1-gb <= y < vmax+1-gb, starts the exit at line y+1. The frame then lasts y+1+gb lines.
- R5: A push pending before the earliest boundary is held. The exit starts at line flip+1-gb and the frame lasts flip+1 lines.
- R6: Push-send (address 5, bit 1) clears itself when the exit it caused starts. A write that sets push-send while push-enable (bit 0 of the same write) is 0 is ignored, and push-send reads back 0.
- R7: `reg_latch` pulses for one cycle at the start of the exit, with `line_num` equal to the exit line. The limits, guardband, flipline enable and vsync offsets take new values only then.
- R8: When min, max and flipline are equal, every frame lasts the same number of lines regardless of pushes.
- R9: Control word: bit 0 enables variable timing, bit 1 enables the flipline boundary, bits 15:8 hold the guardband. With bit 1 clear, pushes do not shorten a frame.
- R10: `vsync` is high on lines flip+1-start up to, but not including, flip+1-end. Start is held in address 4 bits 11:0 and end in bits 27:16, both counted back from the flipline total.
- R11: `vblank` is high from line vmin+1-gb until the frame wraps.
- R12: `vrr_live` follows control bit 0 only at a frame start. After the bit is cleared, it stays high until the current frame ends.
- R13: `frame_start` is a one-cycle pulse seen when `line_num` has wrapped to 0.
- R14: A push-send write in the same cycle as a line tick is not seen by that tick's decision. A push written in the cycle the exit starts survives for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| line_tick | input | 1 | One-cycle pulse at each scanline start |
| vblank | output | 1 | Vertical blanking level |
| vsync | output | 1 | Vertical sync level |
| frame_start | output | 1 | One-cycle pulse at line counter wrap |
| reg_latch | output | 1 | One-cycle pulse when the exit starts and the shadows load |
| vrr_live | output | 1 | Variable timing currently in effect |
| line_num | output | 12 | Current line number |

## Verification
A host write to push-send can land in the same clock cycle as the line tick that evaluates a decision boundary. The bench provokes this in two ways. In the first, the push write coincides with the tick that reaches the earliest boundary; the frame must then exit one line later, at 13 lines rather than 12. In the second, the push write coincides with the tick that reaches the vmax boundary; the exit must still start, the frame must last 20 lines, push-send must read back set, and the following frame must end at the flipline total. Both cases are judged from the frame length counted between `frame_start` pulses and from the push register read back.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_VB_WAIT = 2'd1,
        ST_VB_EXIT = 2'd2
    } vtg_state_e;

    localparam logic [2:0] ADR_VMIN  = 3'd0;
    localparam logic [2:0] ADR_VMAX  = 3'd1;
    localparam logic [2:0] ADR_FLIP  = 3'd2;
    localparam logic [2:0] ADR_CTRL  = 3'd3;
    localparam logic [2:0] ADR_VSYNC = 3'd4;
    localparam logic [2:0] ADR_PUSH  = 3'd5;
    localparam logic [2:0] ADR_STAT  = 3'd6;

    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_FLIP_BIT  = 1;
    localparam int CTL_GB_LSB    = 8;
    localparam int VS_START_LSB  = 0;
    localparam int VS_END_LSB    = 16;
    localparam int PUSH_EN_BIT   = 0;
    localparam int PUSH_SEND_BIT = 1;

endpackage

// File: rtl/vtg_regfile.sv
module vtg_regfile
    import vtg_pkg::*;
#(
    parameter int LW  = 12,
    parameter int GBW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr,
    input  logic [2:0]     addr,
    input  logic [31:0]    wdata,
    output logic [31:0]    rdata,
    input  logic           latch_now,
    input  logic           consume,
    input  logic           live,
    output logic [LW-1:0]  sh_min,
    output logic [LW-1:0]  sh_max,
    output logic [LW-1:0]  sh_flip,
    output logic [GBW-1:0] sh_gb,
    output logic           sh_flip_on,
    output logic [LW-1:0]  sh_vss,
    output logic [LW-1:0]  sh_vse,
    output logic           ctl_en,
    output logic           push_en,
    output logic           push_send
);

    logic [LW-1:0]  p_min, p_max, p_flip, p_vss, p_vse;
    logic [GBW-1:0] p_gb;
    logic           p_flip_on;
    logic           wr_push;

    assign wr_push = wr && (addr == ADR_PUSH);

    always_ff @(posedge clk) begin
        if (rst) begin
            p_min      <= '0;
            p_max      <= '0;
            p_flip     <= '0;
            p_vss      <= '0;
            p_vse      <= '0;
            p_gb       <= '0;
            p_flip_on  <= 1'b0;
            ctl_en     <= 1'b0;
            push_en    <= 1'b0;
            push_send  <= 1'b0;
        end else begin
            // hardware clear first, so a same-cycle host write wins
            if (consume)
                push_send <= 1'b0;
            if (wr) begin
                unique case (addr)
                    ADR_VMIN:  p_min <= wdata[LW-1:0];
                    ADR_VMAX:  p_max <= wdata[LW-1:0];
                    ADR_FLIP:  p_flip <= wdata[LW-1:0];
                    ADR_CTRL: begin
                        ctl_en    <= wdata[CTL_EN_BIT];
                        p_flip_on <= wdata[CTL_FLIP_BIT];
                        p_gb      <= wdata[CTL_GB_LSB +: GBW];
                    end
                    ADR_VSYNC: begin
                        p_vss <= wdata[VS_START_LSB +: LW];
                        p_vse <= wdata[VS_END_LSB +: LW];
                    end
                    ADR_PUSH: begin
                        push_en   <= wdata[PUSH_EN_BIT];
                        push_send <= wdata[PUSH_EN_BIT] & wdata[PUSH_SEND_BIT];
                    end
                    default: ;
                endcase
            end
        end
    end

    // shadow copies used by the sequencer, loaded at the exit start
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_min     <= '0;
            sh_max     <= '0;
            sh_flip    <= '0;
            sh_gb      <= '0;
            sh_flip_on <= 1'b0;
            sh_vss     <= '0;
            sh_vse     <= '0;
        end else if (latch_now) begin
            sh_min     <= p_min;
            sh_max     <= p_max;
            sh_flip    <= p_flip;
            sh_gb      <= p_gb;
            sh_flip_on <= p_flip_on;
            sh_vss     <= p_vss;
            sh_vse     <= p_vse;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADR_VMIN:  rdata[LW-1:0] = p_min;
            ADR_VMAX:  rdata[LW-1:0] = p_max;
            ADR_FLIP:  rdata[LW-1:0] = p_flip;
            ADR_CTRL: begin
                rdata[CTL_EN_BIT]          = ctl_en;
                rdata[CTL_FLIP_BIT]        = p_flip_on;
                rdata[CTL_GB_LSB +: GBW]   = p_gb;
            end
            ADR_VSYNC: begin
                rdata[VS_START_LSB +: LW]  = p_vss;
                rdata[VS_END_LSB +: LW]    = p_vse;
            end
            ADR_PUSH: begin
                rdata[PUSH_EN_BIT]         = push_en;
                rdata[PUSH_SEND_BIT]       = push_send;
            end
            ADR_STAT:  rdata[0] = live;
            default:   rdata = '0;
        endcase
    end

    AST_PUSH_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_push && !wdata[PUSH_EN_BIT]) |=> !push_send); // R6
    AST_PUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (consume && !wr_push) |=> !push_send); // R6
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !latch_now |=> ($stable(sh_max) && $stable(sh_flip) && $stable(sh_gb))); // R7

endmodule

// File: rtl/vtg_frame_fsm.sv
module vtg_frame_fsm
    import vtg_pkg::*;
#(
    parameter int LW  = 12,
    parameter int GBW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           line_tick,
    input  logic [LW-1:0]  sh_min,
    input  logic [LW-1:0]  sh_max,
    input  logic [LW-1:0]  sh_flip,
    input  logic [GBW-1:0] sh_gb,
    input  logic           sh_flip_on,
    input  logic [LW-1:0]  sh_vss,
    input  logic [LW-1:0]  sh_vse,
    input  logic           ctl_en,
    input  logic           push_en,
    input  logic           push_send,
    output logic           latch_now,
    output logic           consume,
    output logic           vblank,
    output logic           vsync,
    output logic           frame_start,
    output logic           reg_latch,
    output logic           live,
    output logic [LW-1:0]  line_num
);

    localparam int TW = LW + 1;

    vtg_state_e     state_q, state_d;
    logic [LW-1:0]  cnt_q, cnt_d;
    logic [GBW-1:0] rem_q, rem_d;
    logic           wrap;
    logic           fs_q, latch_q, live_q;

    logic [TW-1:0]  min_t, max_t, flip_t, gbe;
    logic [TW-1:0]  vbs, lat, earl, nxt, cur, vs_a, vs_b;
    logic           push_ok, exit_hit;

    // totals are stored minus one; restore the line counts here
    assign min_t  = TW'(sh_min) + TW'(1);
    assign max_t  = TW'(sh_max) + TW'(1);
    assign flip_t = TW'(sh_flip) + TW'(1);
    assign gbe    = (sh_gb == '0) ? TW'(1) : TW'(sh_gb);

    assign vbs  = (min_t > gbe) ? (min_t - gbe) : '0;
    assign lat  = (max_t > gbe) ? (max_t - gbe) : '0;
    assign earl = (live_q && sh_flip_on) ?
                  ((flip_t > gbe) ? (flip_t - gbe) : '0) : lat;

    assign cur      = TW'(cnt_q);
    assign nxt      = cur + TW'(1);
    assign push_ok  = live_q && push_en && push_send;
    assign exit_hit = (nxt >= lat) || (push_ok && (nxt >= earl));

    // next-state process
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        rem_d     = rem_q;
        latch_now = 1'b0;
        wrap      = 1'b0;
        if (line_tick) begin
            unique case (state_q)
                ST_ACTIVE, ST_VB_WAIT: begin
                    cnt_d = nxt[LW-1:0];
                    if (exit_hit) begin
                        state_d   = ST_VB_EXIT;
                        rem_d     = GBW'(gbe - TW'(1));
                        latch_now = 1'b1;
                    end else if (nxt >= vbs) begin
                        state_d = ST_VB_WAIT;
                    end else begin
                        state_d = ST_ACTIVE;
                    end
                end
                ST_VB_EXIT: begin
                    if (rem_q == '0) begin
                        state_d = ST_ACTIVE;
                        cnt_d   = '0;
                        wrap    = 1'b1;
                    end else begin
                        rem_d = rem_q - GBW'(1);
                        cnt_d = nxt[LW-1:0];
                    end
                end
                default: state_d = ST_ACTIVE;
            endcase
        end
    end

    assign consume = latch_now && push_ok;

    // state register process
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ACTIVE;
            cnt_q   <= '0;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rem_q   <= rem_d;
        end
    end

    // registered output process
    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q    <= 1'b0;
            latch_q <= 1'b0;
            live_q  <= 1'b0;
        end else begin
            fs_q    <= wrap;
            latch_q <= latch_now;
            if (wrap)
                live_q <= ctl_en;
        end
    end

    assign vs_a        = (flip_t > TW'(sh_vss)) ? (flip_t - TW'(sh_vss)) : '0;
    assign vs_b        = (flip_t > TW'(sh_vse)) ? (flip_t - TW'(sh_vse)) : '0;
    assign vsync       = (cur >= vs_a) && (cur < vs_b);
    assign vblank      = (state_q != ST_ACTIVE);
    assign frame_start = fs_q;
    assign reg_latch   = latch_q;
    assign live        = live_q;
    assign line_num    = cnt_q;

    AST_FS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fs_q |=> !fs_q); // R13
    AST_FS_LINE_ZERO: assert property (@(posedge clk) disable iff (rst)
        fs_q |-> (cnt_q == '0 && state_q == ST_ACTIVE)); // R13
    AST_LIVE_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
        !$stable(live_q) |-> fs_q); // R12
    AST_LATCH_IN_EXIT: assert property (@(posedge clk) disable iff (rst)
        latch_q |-> (state_q == ST_VB_EXIT)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !line_tick |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/vrr_vtiming.sv
module vrr_vtiming
    import vtg_pkg::*;
#(
    parameter int LW  = 12,
    parameter int GBW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          line_tick,
    output logic          vblank,
    output logic          vsync,
    output logic          frame_start,
    output logic          reg_latch,
    output logic          vrr_live,
    output logic [LW-1:0] line_num
);

    logic [LW-1:0]  sh_min, sh_max, sh_flip, sh_vss, sh_vse;
    logic [GBW-1:0] sh_gb;
    logic           sh_flip_on, ctl_en, push_en, push_send;
    logic           latch_now, consume;

    vtg_regfile #(.LW(LW), .GBW(GBW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .latch_now  (latch_now),
        .consume    (consume),
        .live       (vrr_live),
        .sh_min     (sh_min),
        .sh_max     (sh_max),
        .sh_flip    (sh_flip),
        .sh_gb      (sh_gb),
        .sh_flip_on (sh_flip_on),
        .sh_vss     (sh_vss),
        .sh_vse     (sh_vse),
        .ctl_en     (ctl_en),
        .push_en    (push_en),
        .push_send  (push_send)
    );

    vtg_frame_fsm #(.LW(LW), .GBW(GBW)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .line_tick   (line_tick),
        .sh_min      (sh_min),
        .sh_max      (sh_max),
        .sh_flip     (sh_flip),
        .sh_gb       (sh_gb),
        .sh_flip_on  (sh_flip_on),
        .sh_vss      (sh_vss),
        .sh_vse      (sh_vse),
        .ctl_en      (ctl_en),
        .push_en     (push_en),
        .push_send   (push_send),
        .latch_now   (latch_now),
        .consume     (consume),
        .vblank      (vblank),
        .vsync       (vsync),
        .frame_start (frame_start),
        .reg_latch   (reg_latch),
        .live        (vrr_live),
        .line_num    (line_num)
    );

endmodule

// File: tb/vrr_vtiming_bench.sv
module vrr_vtiming_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LW = 12;
    // configuration under test, in lines
    localparam int MINL = 10, FLIPL = 12, MAXL = 20, GB = 3, VSS = 5, VSE = 3;
    localparam int EARLY = FLIPL - GB, LATE = MAXL - GB, VBS = MINL - GB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic line_tick = 1'b0;
    logic vblank, vsync, frame_start, reg_latch, vrr_live;
    logic [LW-1:0] line_num;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vrr_vtiming u_vrr_vtiming (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_tick(line_tick),
        .vblank(vblank), .vsync(vsync), .frame_start(frame_start),
        .reg_latch(reg_latch), .vrr_live(vrr_live), .line_num(line_num)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        line_tick = 1'b1;
        @(negedge clk);
        line_tick = 1'b0;
    endtask

    // line tick and push write in the same clock cycle
    task automatic tick_push();
        @(negedge clk);
        line_tick = 1'b1; reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 32'd3;
        @(negedge clk);
        line_tick = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic sync_frame();
        int g = 0;
        do begin tick(); g++; end while (!frame_start && g < 200);
    endtask

    // runs one frame from frame start; pushes during line y (y<0: none)
    task automatic run_frame(input int y, input bit cl, output int len, output int xl);
        len = 0; xl = -1;
        if (y == 0) wr(3'd5, 32'd3);
        while (len < 200) begin
            tick(); len++;
            if (reg_latch) xl = int'(line_num);
            if (frame_start) break;
            if (cl) begin
                chk(vblank == (int'(line_num) >= VBS), "R11 vblank", int'(vblank), int'(int'(line_num) >= VBS));
                chk(vsync == (int'(line_num) >= FLIPL - VSS && int'(line_num) < FLIPL - VSE),
                    "R10 vsync", int'(vsync), int'(int'(line_num) >= FLIPL - VSS && int'(line_num) < FLIPL - VSE));
            end
            if (int'(line_num) == y) wr(3'd5, 32'd3);
        end
    endtask

    task automatic program_limits(input int mn, input int fl, input int mx);
        wr(3'd0, 32'(mn - 1));
        wr(3'd2, 32'(fl - 1));
        wr(3'd1, 32'(mx - 1));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int len, xl, ex, el;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk({vblank, vsync, frame_start, reg_latch, vrr_live} == 5'b0, "R1 outputs",
            int'({vblank, vsync, frame_start, reg_latch, vrr_live}), 0);
        chk(line_num == '0, "R1 line", int'(line_num), 0);
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), d);
            chk(d == 32'd0, "R1 register", int'(d), 0);
        end

        program_limits(MINL, FLIPL, MAXL);
        wr(3'd4, 32'(VSS) | (32'(VSE) << 16));
        wr(3'd3, 32'h1 | 32'h2 | (32'(GB) << 8));   // R9 field layout
        wr(3'd5, 32'd1);
        repeat (3) sync_frame();
        chk(vrr_live == 1'b1, "R12 live rise", int'(vrr_live), 1);

        // sweep of push line across the whole frame
        for (int y = -1; y < MAXL; y++) begin
            run_frame(y, 1'b1, len, xl);
            ex = (y < 0) ? LATE : (y < EARLY) ? EARLY : (y < LATE) ? y + 1 : LATE;
            el = ex + GB;
            if (y < 0)          chk(len == el, "R3 no push length", len, el);
            else if (y < EARLY) chk(len == el, "R5 held push length", len, el);
            else                chk(len == el, "R4 push length", len, el);
            chk(xl == ex, "R7 latch line", xl, ex);
            rd(3'd5, d);
            chk(d == ((y >= LATE) ? 32'd3 : 32'd1), "R6 push self clear", int'(d), (y >= LATE) ? 3 : 1);
            if (y >= LATE) begin
                run_frame(-1, 1'b1, len, xl);
                chk(len == FLIPL, "R5 carried push length", len, FLIPL);
                rd(3'd5, d);
                chk(d == 32'd1, "R6 carried push cleared", int'(d), 1);
            end
        end

        // R6 push-send without push-enable is ignored
        wr(3'd5, 32'd2);
        rd(3'd5, d);
        chk(d == 32'd0, "R6 ignored push readback", int'(d), 0);
        run_frame(-1, 1'b0, len, xl);
        chk(len == MAXL, "R6 ignored push length", len, MAXL);
        wr(3'd5, 32'd1);

        // R14 push write coincident with tick reaching earliest boundary
        len = 0;
        repeat (EARLY - 1) begin tick(); len++; end
        tick_push(); len++;
        while (!frame_start && len < 200) begin tick(); len++; end
        chk(len == EARLY + 1 + GB, "R14 coincident early", len, EARLY + 1 + GB);

        // R14 push write coincident with tick reaching vmax boundary
        len = 0; xl = -1;
        repeat (LATE - 1) begin tick(); len++; end
        tick_push(); len++;
        if (reg_latch) xl = int'(line_num);
        while (!frame_start && len < 200) begin tick(); len++; end
        chk(len == MAXL, "R14 coincident late length", len, MAXL);
        chk(xl == LATE, "R14 coincident late latch", xl, LATE);
        rd(3'd5, d);
        chk(d == 32'd3, "R14 push survives", int'(d), 3);
        run_frame(-1, 1'b0, len, xl);
        chk(len == FLIPL, "R14 next frame early", len, FLIPL);

        // R9 flipline boundary disabled: pushes do not shorten
        wr(3'd3, 32'h1 | (32'(GB) << 8));
        run_frame(-1, 1'b0, len, xl);
        run_frame(EARLY, 1'b0, len, xl);
        chk(len == MAXL, "R9 flip disabled length", len, MAXL);
        wr(3'd3, 32'h3 | (32'(GB) << 8));
        run_frame(-1, 1'b0, len, xl);

        // R8 equal limits: constant frame length
        program_limits(15, 15, 15);
        run_frame(-1, 1'b0, len, xl);
        foreach (ex_list[i]) begin
            run_frame(ex_list[i], 1'b0, len, xl);
            chk(len == 15, "R8 equal limits length", len, 15);
        end
        wr(3'd5, 32'd1);

        // R12 live falls only at frame end; R2 fixed timing
        wr(3'd3, 32'h2 | (32'(GB) << 8));
        chk(vrr_live == 1'b1, "R12 live holds", int'(vrr_live), 1);
        run_frame(-1, 1'b0, len, xl);
        chk(vrr_live == 1'b0, "R12 live drop", int'(vrr_live), 0);
        program_limits(MINL, FLIPL, MAXL);
        run_frame(-1, 1'b0, len, xl);
        run_frame(3, 1'b1, len, xl);
        chk(len == MAXL, "R2 fixed length with push", len, MAXL);
        run_frame(-1, 1'b0, len, xl);
        chk(len == MAXL, "R2 fixed length", len, MAXL);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    int ex_list [5] = '{-1, 0, 5, 11, 13};

endmodule